// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits between a command register interface and a behavioural flash array held in on-chip storage. A caller presents one command per cycle on `cmd_valid`. The command is either a single 16-bit word program or an erase. An erase can cover an aligned sector, an aligned block or the whole array. The sequencer checks the command against two write-protect inputs. One guards a fixed region at the top of the address space and the other guards everything. If the command is allowed, the sequencer holds `busy` for the duration that belongs to that operation and then updates the array.

Durations are cycle counts. By default they come from a clock-frequency parameter: about 20 us for a word program, 25 ms for a sector or block erase and 100 ms for a chip erase. An integration or a bench can override them. The array geometry is also parameterized: words in the array, words per sector, words per block, and the size of the protected top region. Erased words read as all ones, and programming can only clear bits. The array can be read at any time through a combinational read port.

A command is refused when it is rejected by protection or when it arrives while `busy` is high. A refused command pulses `err` and changes nothing.

Top module: `flash_seq`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0 and every array word reads 16'hFFFF on `rd_data`.
- R2: An accepted program command (`cmd_op` = 0) replaces the addressed word with old AND `cmd_data` and leaves every other word unchanged; `busy` is high for exactly PROG_CYC cycles starting the cycle after acceptance.
- R3: An accepted sector erase (`cmd_op` = 1) sets to 16'hFFFF every word of the SECTOR_WORDS-aligned sector containing `cmd_addr`, leaves the others unchanged, and holds `busy` for exactly SECT_CYC cycles.
- R4: An accepted block erase (`cmd_op` = 2) sets to 16'hFFFF every word of the BLOCK_WORDS-aligned block containing `cmd_addr`, leaves the others unchanged, and holds `busy` for exactly BLK_CYC cycles.
- R5: An accepted chip erase (`cmd_op` = 3) sets every word to 16'hFFFF and holds `busy` for exactly CHIP_CYC cycles.
- R6: `done` is high for exactly one cycle, the first cycle after `busy` falls, and at no other time.
- R7: With `prot_block` high, a command is rejected if any word it would change lies in the top PROT_WORDS words. The word just below that region is still writable. A chip erase is always rejected in this case. On rejection `err` is high for one cycle, `busy` stays low and the array is unchanged.
- R8: With `prot_chip` high, every command is rejected the same way as in R7.
- R9: A command presented while `busy` is high is ignored and pulses `err` the next cycle. The running operation keeps its duration and its result.
- R10: A command presented while idle produces, on the next cycle, exactly one of `busy` (accepted) or `err` (rejected).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| cmd_addr | input | $clog2(ARRAY_WORDS) | Word address; low bits ignored for erases |
| cmd_data | input | 16 | Program data |
| prot_block | input | 1 | Protect the top PROT_WORDS words |
| prot_chip | input | 1 | Protect the whole array |
| rd_addr | input | $clog2(ARRAY_WORDS) | Read word address |
| rd_data | output | 16 | Combinational read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |

## Verification
The checker follows the handshake on every cycle. It confirms that each busy period lasts exactly the duration of the operation that started it. It confirms that `done` appears only as a one-cycle pulse right after `busy` falls. It also confirms that an idle command yields either `busy` or `err` and never both, that chip protect always refuses, and that a command arriving while busy always raises `err`. Only the bench scenarios can show which words an operation changed or left alone. They compare the whole array against a reference model after every command, including the AND behaviour of repeated programs, the edges of sectors and blocks, the boundary of the protected region, and a collision during a long erase.

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int ARRAY_WORDS  = 256,
  parameter int SECTOR_WORDS = 8,
  parameter int BLOCK_WORDS  = 64,
  parameter int PROT_WORDS   = 16,
  parameter int CLK_KHZ      = 50000,
  parameter int PROG_CYC     = CLK_KHZ * 20 / 1000,
  parameter int SECT_CYC     = CLK_KHZ * 25,
  parameter int BLK_CYC      = CLK_KHZ * 25,
  parameter int CHIP_CYC     = CLK_KHZ * 100
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cmd_valid,
  input  logic [1:0]                     cmd_op,
  input  logic [$clog2(ARRAY_WORDS)-1:0] cmd_addr,
  input  logic [15:0]                    cmd_data,
  input  logic                           prot_block,
  input  logic                           prot_chip,
  input  logic [$clog2(ARRAY_WORDS)-1:0] rd_addr,
  output logic [15:0]                    rd_data,
  output logic                           busy,
  output logic                           done,
  output logic                           err
);
  localparam int AW    = $clog2(ARRAY_WORDS);
  localparam int MAX1  = PROG_CYC > SECT_CYC ? PROG_CYC : SECT_CYC;
  localparam int MAX2  = BLK_CYC > CHIP_CYC ? BLK_CYC : CHIP_CYC;
  localparam int LONG  = MAX1 > MAX2 ? MAX1 : MAX2;
  localparam int CW    = $clog2(LONG + 1);
  localparam logic [AW:0] PBASE = (AW+1)'(ARRAY_WORDS - PROT_WORDS);

  typedef enum logic [1:0] {OP_PROG, OP_SECT, OP_BLK, OP_CHIP} op_e;

  logic [15:0]   mem [ARRAY_WORDS];
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [15:0]   data_q;
  logic [CW-1:0] cnt;
  logic [AW:0]   span_hi;
  logic [CW-1:0] dur;
  logic          hit, accept, finish;

  always_comb begin
    case (op_e'(cmd_op))
      OP_PROG: begin span_hi = {1'b0, cmd_addr};                                  dur = CW'(PROG_CYC); end
      OP_SECT: begin span_hi = {1'b0, cmd_addr} | (AW+1)'(SECTOR_WORDS - 1);      dur = CW'(SECT_CYC); end
      OP_BLK:  begin span_hi = {1'b0, cmd_addr} | (AW+1)'(BLOCK_WORDS - 1);       dur = CW'(BLK_CYC);  end
      default: begin span_hi = (AW+1)'(ARRAY_WORDS - 1);                          dur = CW'(CHIP_CYC); end
    endcase
  end

  assign hit     = prot_chip || (prot_block && span_hi >= PBASE);
  assign accept  = cmd_valid && !busy && !hit;
  assign finish  = busy && cnt == '0;
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      cnt    <= '0;
      op_q   <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      err  <= cmd_valid && (busy || hit);
      done <= finish;
      if (accept) begin
        busy   <= 1'b1;
        cnt    <= dur - 1'b1;
        op_q   <= op_e'(cmd_op);
        addr_q <= cmd_addr;
        data_q <= cmd_data;
      end else if (finish) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARRAY_WORDS; i++) mem[i] <= 16'hFFFF;
    end else if (finish) begin
      for (int i = 0; i < ARRAY_WORDS; i++) begin
        case (op_q)
          OP_PROG: if (i == int'(addr_q)) mem[i] <= mem[i] & data_q;
          OP_SECT: if (i / SECTOR_WORDS == int'(addr_q) / SECTOR_WORDS) mem[i] <= 16'hFFFF;
          OP_BLK:  if (i / BLOCK_WORDS == int'(addr_q) / BLOCK_WORDS) mem[i] <= 16'hFFFF;
          default: mem[i] <= 16'hFFFF;
        endcase
      end
    end
  end
endmodule

module flash_seq_chk #(
  parameter int PROG_CYC = 1,
  parameter int SECT_CYC = 1,
  parameter int BLK_CYC  = 1,
  parameter int CHIP_CYC = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       prot_chip,
  input logic       busy,
  input logic       done,
  input logic       err
);
  int         run;
  int         want;
  logic [1:0] op_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 0;
      op_seen <= 2'd0;
    end else begin
      run <= busy ? run + 1 : 0;
      if (cmd_valid && !busy) op_seen <= cmd_op;
    end
  end

  always_comb begin
    case (op_seen)
      2'd0:    want = PROG_CYC;
      2'd1:    want = SECT_CYC;
      2'd2:    want = BLK_CYC;
      default: want = CHIP_CYC;
    endcase
  end

  // R2 R3 R4 R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run == want);

  // R6
  done_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R6
  done_only_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy));

  // R10
  start_or_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> (busy != err));

  // R8
  chip_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && prot_chip) |=> (err && !busy));

  // R9
  collide_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy) |=> err);
endmodule

bind flash_seq flash_seq_chk #(
  .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .BLK_CYC(BLK_CYC), .CHIP_CYC(CHIP_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .prot_chip(prot_chip), .busy(busy), .done(done), .err(err)
);

// File: tb/flash_seq_tb.sv
module flash_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 256;
  localparam int SECT  = 8;
  localparam int BLK   = 64;
  localparam int PROT  = 16;
  localparam int PCYC  = 3;
  localparam int SCYC  = 5;
  localparam int BCYC  = 7;
  localparam int CCYC  = 9;
  localparam int AW    = $clog2(WORDS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [15:0]   cmd_data = '0;
  logic          prot_block = 1'b0;
  logic          prot_chip = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [15:0]   rd_data;
  logic          busy, done, err;

  logic [15:0] model [WORDS];
  int checks = 0;
  int fails = 0;
  bit ended = 0;

  flash_seq #(
    .ARRAY_WORDS(WORDS), .SECTOR_WORDS(SECT), .BLOCK_WORDS(BLK), .PROT_WORDS(PROT),
    .PROG_CYC(PCYC), .SECT_CYC(SCYC), .BLK_CYC(BCYC), .CHIP_CYC(CCYC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .prot_block(prot_block),
    .prot_chip(prot_chip), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done(done), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int span_lo(input int op, input int a);
    case (op)
      0: return a;
      1: return a / SECT * SECT;
      2: return a / BLK * BLK;
      default: return 0;
    endcase
  endfunction

  function automatic int span_hi(input int op, input int a);
    case (op)
      0: return a;
      1: return a / SECT * SECT + SECT - 1;
      2: return a / BLK * BLK + BLK - 1;
      default: return WORDS - 1;
    endcase
  endfunction

  function automatic int op_dur(input int op);
    case (op)
      0: return PCYC;
      1: return SCYC;
      2: return BCYC;
      default: return CCYC;
    endcase
  endfunction

  function automatic string op_req(input int op);
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic apply_model(input int op, input int a, input logic [15:0] d);
    for (int i = span_lo(op, a); i <= span_hi(op, a); i++)
      model[i] = (op == 0) ? (model[i] & d) : 16'hFFFF;
  endtask

  task automatic sweep(input string req);
    int bad = 0;
    int first = -1;
    for (int a = 0; a < WORDS; a++) begin
      rd_addr = AW'(a);
      #1;
      if (rd_data !== model[a]) begin
        bad++;
        if (first < 0) first = a;
      end
    end
    chk(bad == 0, req, bad, 0);
    if (bad != 0) $display("  first mismatch at word %0d", first);
    @(negedge clk);
  endtask

  task automatic run_cmd(input int op, input int a, input logic [15:0] d,
                         input bit pb, input bit pc, input string req);
    bit ok = !(pc || (pb && span_hi(op, a) >= WORDS - PROT));
    int n = 0;
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_addr = AW'(a); cmd_data = d;
    prot_block = pb; prot_chip = pc;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (ok) begin
      chk(busy === 1'b1 && err === 1'b0, {req, " start"}, int'(busy), 1);
      while (busy === 1'b1 && n < 1000) begin n++; @(negedge clk); end
      chk(n == op_dur(op), {op_req(op), " busy length"}, n, op_dur(op));
      chk(done === 1'b1, "R6 done pulse", int'(done), 1);
      @(negedge clk);
      chk(done === 1'b0, "R6 done one cycle", int'(done), 0);
      apply_model(op, a, d);
    end else begin
      chk(err === 1'b1 && busy === 1'b0, {req, " reject"}, int'(err), 1);
      @(negedge clk);
      chk(err === 1'b0 && busy === 1'b0, {req, " reject settles"}, int'(err), 0);
    end
    prot_block = 1'b0; prot_chip = 1'b0;
    sweep({req, " array"});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R1 status after reset", int'(busy), 0);
    sweep("R1 erased after reset");

    // R2: program and AND behaviour
    run_cmd(0, 5, 16'hA5A5, 0, 0, "R2");
    run_cmd(0, 5, 16'h0F0F, 0, 0, "R2");
    run_cmd(0, 7, 16'h1234, 0, 0, "R2");
    run_cmd(0, 8, 16'h00FF, 0, 0, "R2");
    // R3: sector 0..7 cleared, word 8 kept
    run_cmd(1, 3, 16'h0000, 0, 0, "R3");
    // R4: block 64..127 cleared, 130 kept
    run_cmd(0, 70, 16'h0001, 0, 0, "R2");
    run_cmd(0, 127, 16'h8000, 0, 0, "R2");
    run_cmd(0, 130, 16'h4444, 0, 0, "R2");
    run_cmd(2, 65, 16'h0000, 0, 0, "R4");
    // R5
    run_cmd(0, 200, 16'h0000, 0, 0, "R2");
    run_cmd(5 - 2, 17, 16'h0000, 0, 0, "R5");

    // R7: boundary of the protected top region
    run_cmd(0, 239, 16'h00F0, 1, 0, "R7 below region");
    run_cmd(0, 240, 16'h0000, 1, 0, "R7");
    run_cmd(0, 255, 16'h0000, 1, 0, "R7");
    run_cmd(1, 241, 16'h0000, 1, 0, "R7");
    run_cmd(1, 232, 16'h0000, 1, 0, "R7 sector below region");
    run_cmd(2, 200, 16'h0000, 1, 0, "R7");
    run_cmd(3, 0, 16'h0000, 1, 0, "R7");
    // R8
    run_cmd(0, 0, 16'h0000, 0, 1, "R8");
    run_cmd(2, 0, 16'h0000, 0, 1, "R8");

    // R9: collision during a chip erase
    run_cmd(0, 3, 16'h0000, 0, 0, "R2");
    begin
      int n = 1;
      cmd_valid = 1'b1; cmd_op = 2'd3; cmd_addr = '0; cmd_data = '0;
      @(negedge clk);
      chk(busy === 1'b1, "R9 long erase started", int'(busy), 1);
      cmd_op = 2'd0; cmd_addr = AW'(20); cmd_data = 16'h0000;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(err === 1'b1 && busy === 1'b1, "R9 collision flagged", int'(err), 1);
      while (busy === 1'b1 && n < 1000) begin n++; @(negedge clk); end
      chk(n == CCYC, "R9 duration kept", n, CCYC);
      chk(done === 1'b1, "R6 done after collision", int'(done), 1);
      for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
      @(negedge clk);
      sweep("R9 collision ignored");
    end

    // random mix, R2 to R8
    for (int k = 0; k < 60; k++) begin
      int r = int'($urandom % 8);
      int op = (r < 5) ? 0 : r - 4;
      int a = int'($urandom % WORDS);
      logic [15:0] d = 16'($urandom);
      bit pb = ($urandom % 4) == 0;
      bit pc = ($urandom % 10) == 0;
      run_cmd(op, a, d, pb, pc, pc ? "R8" : (pb ? "R7" : op_req(op)));
    end

    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule